// File: doc/BRIEF.md
# Code-Selected Bus Clock Divider

This block derives a bus clock from a faster input clock. The divide ratio is chosen with a 4-bit code, and the code is turned into a ratio by a fixed, non-linear decode. Codes with the top bit clear give ratios 1 to 8. Codes with the top bit set give either the odd ratios 1, 3, 5 and 7 or the even ratios 10, 12, 14 and 16. The decoded ratio is also driven on a port, so that it can be observed directly.

A code is taken in only when the commit strobe is high at a rising input edge while the divider is held in reset. A ratio therefore never changes while the divided clock is running. A power-on reset clears the stored code to the default of 0000, which means pass-through. After the hold reset is released, the divider produces two outputs:
- a divided clock whose duty cycle is as close to half as the ratio allows;
- a one-cycle clock-enable pulse at the start of every output period.

The control is a small state machine with four states:
- HOLD is the reset state.
- PASS is used for ratio 1.
- HIGH and LOW are the two phases of the divided clock.

Its transitions are:
- HOLD to PASS at the first edge after release when the ratio is 1.
- HOLD to HIGH at that edge when the ratio is greater than 1.
- HIGH to LOW when the in-period count reaches half the ratio.
- LOW to HIGH when the count wraps to zero.
- PASS stays in PASS until reset.
- Any state returns to HOLD asynchronously when the hold reset is asserted.

Top module: `enc_ratio_clkdiv`

## Requirements
- R1: After power-on reset, with no commit, the stored code is 0000 and ratio_o reads 1.
- R2: Code 0000 decodes to ratio 1, and codes 0001 to 0111 decode to the code value plus 1. The decoded ratio appears on ratio_o.
- R3: Codes 1001, 1011, 1101 and 1111 decode to 10, 12, 14 and 16. Codes 1000, 1010, 1100 and 1110 decode to 1, 3, 5 and 7.
- R4: code_i is stored only at a rising clk_i edge where commit_i is 1 and rst_ni is 0. A commit while running has no effect, and a code_i change without a commit has no effect.
- R5: While rst_ni is 0, clk_div_o and clk_en_o are 0 and the period count is cleared.
- R6: At the first rising clk_i edge after rst_ni rises, for ratio N > 1, clk_div_o goes to 1 and clk_en_o pulses in that same cycle.
- R7: For N > 1, clk_en_o is 1 for exactly one input cycle in every N, aligned with each rising edge of clk_div_o.
- R8: For N > 1, clk_div_o has period N input cycles and is high for floor(N/2) cycles, low for the rest.
- R9: For N = 1, from the first edge after release, clk_en_o stays 1 and clk_div_o follows clk_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| por_ni | input | 1 | Power-on reset, active low, async; clears the stored code |
| rst_ni | input | 1 | Divider hold reset (push button), active low, async |
| commit_i | input | 1 | Strobe that stores code_i while rst_ni is low |
| code_i | input | 4 | Ratio selection code |
| clk_div_o | output | 1 | Divided clock |
| clk_en_o | output | 1 | One-cycle enable at the start of each divided period |
| ratio_o | output | 5 | Decoded divide ratio of the stored code |

## Verification
A wrong period count shows at the ports within one output period: either the enable pulse spacing or the high-phase length of clk_div_o breaks, at the latest N input cycles after the fault. A wrong state, such as being stuck in PASS for a ratio above 1 or stuck in HOLD, shows on the first edge after release, because the enable and the divided clock must both rise there. A corrupted stored code shows at once on ratio_o, and it also shows in the output waveform on the next run.

// File: rtl/enc_ratio_clkdiv_pkg.sv
package enc_ratio_clkdiv_pkg;

    localparam int CODE_W  = 4;
    localparam int RATIO_W = 5;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2,
        ST_PASS = 2'd3
    } div_state_e;

endpackage

// File: rtl/ratio_decode.sv
module ratio_decode #(
    parameter int CODE_W  = 4,
    parameter int RATIO_W = 5
) (
    input  logic [CODE_W-1:0]  code_i,
    output logic [RATIO_W-1:0] ratio_o
);
    localparam logic [RATIO_W-1:0] ONE     = RATIO_W'(1);
    localparam logic [RATIO_W-1:0] ODD_LO  = RATIO_W'(1);
    localparam logic [RATIO_W-1:0] EVEN_LO = RATIO_W'(10);

    logic [RATIO_W-1:0] step;

    always_comb begin
        step = RATIO_W'(code_i[CODE_W-2:1]) << 1;
        if (!code_i[CODE_W-1]) begin
            if (code_i == '0) ratio_o = ONE;
            else              ratio_o = RATIO_W'(code_i) + ONE;
        end else if (code_i[0]) begin
            ratio_o = EVEN_LO + step;
        end else begin
            ratio_o = ODD_LO + step;
        end
    end
endmodule

// File: rtl/code_store.sv
module code_store #(
    parameter int CODE_W = 4
) (
    input  logic              clk_i,
    input  logic              por_ni,
    input  logic              rst_ni,
    input  logic              commit_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] code_o
);
    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) begin
            code_o <= '0;
        end else if (!rst_ni && commit_i) begin
            code_o <= code_i;
        end
    end
endmodule

// File: rtl/div_fsm.sv
module div_fsm
    import enc_ratio_clkdiv_pkg::*;
#(
    parameter int RATIO_W = 5
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               clk_div_o,
    output logic               clk_en_o
);
    localparam int CNT_W = RATIO_W;

    div_state_e       state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [CNT_W-1:0] half_w, last_w;
    logic             div_q, en_q;

    assign half_w = ratio_i >> 1;
    assign last_w = ratio_i - CNT_W'(1);

    // next state and count
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            ST_HOLD: begin
                cnt_n   = '0;
                state_n = (ratio_i == CNT_W'(1)) ? ST_PASS : ST_HIGH;
            end
            ST_HIGH, ST_LOW: begin
                cnt_n   = (cnt_q == last_w) ? '0 : cnt_q + CNT_W'(1);
                state_n = (cnt_n < half_w) ? ST_HIGH : ST_LOW;
            end
            ST_PASS: begin
                cnt_n   = '0;
                state_n = ST_PASS;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // output register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_q <= 1'b0;
            en_q  <= 1'b0;
        end else begin
            div_q <= (state_n == ST_HIGH);
            en_q  <= (state_n == ST_PASS) ||
                     ((state_n != ST_HOLD) && (cnt_n == '0));
        end
    end

    assign clk_div_o = (state_q == ST_PASS) ? clk_i : div_q;
    assign clk_en_o  = en_q;
endmodule

// File: rtl/enc_ratio_clkdiv.sv
module enc_ratio_clkdiv
    import enc_ratio_clkdiv_pkg::*;
#(
    parameter int CODE_W  = enc_ratio_clkdiv_pkg::CODE_W,
    parameter int RATIO_W = enc_ratio_clkdiv_pkg::RATIO_W
) (
    input  logic               clk_i,
    input  logic               por_ni,
    input  logic               rst_ni,
    input  logic               commit_i,
    input  logic [CODE_W-1:0]  code_i,
    output logic               clk_div_o,
    output logic               clk_en_o,
    output logic [RATIO_W-1:0] ratio_o
);
    logic [CODE_W-1:0]  code_w;
    logic [RATIO_W-1:0] ratio_w;

    code_store #(.CODE_W(CODE_W)) u_store (
        .clk_i    (clk_i),
        .por_ni   (por_ni),
        .rst_ni   (rst_ni),
        .commit_i (commit_i),
        .code_i   (code_i),
        .code_o   (code_w)
    );

    ratio_decode #(.CODE_W(CODE_W), .RATIO_W(RATIO_W)) u_dec (
        .code_i  (code_w),
        .ratio_o (ratio_w)
    );

    div_fsm #(.RATIO_W(RATIO_W)) u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ratio_i   (ratio_w),
        .clk_div_o (clk_div_o),
        .clk_en_o  (clk_en_o)
    );

    assign ratio_o = ratio_w;
endmodule

// File: rtl/enc_ratio_clkdiv_chk.sv
module enc_ratio_clkdiv_chk #(
    parameter int RATIO_W = 5
) (
    input logic               clk_i,
    input logic               por_ni,
    input logic               rst_ni,
    input logic               clk_div_o,
    input logic               clk_en_o,
    input logic [RATIO_W-1:0] ratio_o
);
    // R5: no enable while held
    a_r5_quiet_in_hold: assert property (@(posedge clk_i) disable iff (!por_ni)
        !rst_ni |-> !clk_en_o);

    // R4: ratio cannot move while running
    a_r4_ratio_frozen: assert property (@(posedge clk_i) disable iff (!por_ni)
        rst_ni |=> $stable(ratio_o));

    // R7: enable is a single-cycle pulse for ratios above 1
    a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
        (clk_en_o && ratio_o > 1) |=> !clk_en_o);

    // R9: enable held high at ratio 1 once running
    a_r9_pass_enable: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
        ($past(rst_ni) && clk_en_o && ratio_o == 1) |=> clk_en_o);

    // R6: divided clock rises on the first edge after release
    a_r6_first_rise: assert property (@(posedge clk_i) disable iff (!por_ni)
        (rst_ni && !$past(rst_ni) && ratio_o > 1) |=> (clk_div_o && clk_en_o));

    // R2 and R3: decoded ratio stays in range
    a_r3_ratio_range: assert property (@(posedge clk_i) disable iff (!por_ni)
        (ratio_o >= 1 && ratio_o <= 16));
endmodule

bind enc_ratio_clkdiv enc_ratio_clkdiv_chk #(.RATIO_W(RATIO_W)) u_chk (
    .clk_i     (clk_i),
    .por_ni    (por_ni),
    .rst_ni    (rst_ni),
    .clk_div_o (clk_div_o),
    .clk_en_o  (clk_en_o),
    .ratio_o   (ratio_o)
);

// File: tb/enc_ratio_clkdiv_tb_top.sv
`timescale 1ns/1ps
module enc_ratio_clkdiv_tb_top;
    logic       clk_i = 1'b0;
    logic       por_ni, rst_ni, commit_i;
    logic [3:0] code_i;
    logic       clk_div_o, clk_en_o;
    logic [4:0] ratio_o;

    typedef struct {
        logic  div;
        logic  en;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    always #2.5 clk_i = ~clk_i;

    enc_ratio_clkdiv dut_i (
        .clk_i     (clk_i),
        .por_ni    (por_ni),
        .rst_ni    (rst_ni),
        .commit_i  (commit_i),
        .code_i    (code_i),
        .clk_div_o (clk_div_o),
        .clk_en_o  (clk_en_o),
        .ratio_o   (ratio_o)
    );

    function automatic int exp_ratio(int c);
        if (c == 0)        return 1;
        else if (c < 8)    return c + 1;
        else if (c % 2)    return 10 + 2 * ((c >> 1) & 3);
        else               return 1 + 2 * ((c >> 1) & 3);
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // monitor: compare one expected item per cycle after each rising edge
    always begin
        exp_t e;
        @(posedge clk_i);
        #1;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            chk(clk_div_o == e.div, e.tag, "clk_div_o", int'(clk_div_o), int'(e.div));
            chk(clk_en_o == e.en, e.tag, "clk_en_o", int'(clk_en_o), int'(e.en));
        end
    end

    // driver: commit (optionally), push expected waveform, release, return to reset
    task automatic run_code(int c, bit do_commit, bit disturb, int periods);
        int   n, h, want;
        exp_t e;
        want = do_commit ? exp_ratio(c) : int'(ratio_o);
        @(negedge clk_i);
        if (do_commit) begin
            code_i = 4'(c); commit_i = 1'b1;
            @(negedge clk_i);
            commit_i = 1'b0;
            chk(ratio_o == 5'(want), (c < 8) ? "R2" : "R3", "ratio_o", int'(ratio_o), want);
        end
        chk(!clk_div_o && !clk_en_o, "R5", "outputs in hold", int'({clk_div_o, clk_en_o}), 0);
        n = want; h = n / 2;
        for (int i = 0; i < periods * n; i++) begin
            if (n == 1)      e = '{1'b1, 1'b1, "R9"};
            else if (i == 0) e = '{1'b1, 1'b1, "R6"};
            else             e = '{((i % n) < h), ((i % n) == 0), "R7 R8"};
            sb_q.push_back(e);
        end
        rst_ni = 1'b1;
        if (disturb) begin
            @(negedge clk_i); @(negedge clk_i);
            code_i = ~4'(c); commit_i = 1'b1;
            @(negedge clk_i);
            commit_i = 1'b0;
        end
        wait (sb_q.size() == 0);
        if (disturb)
            chk(ratio_o == 5'(want), "R4", "ratio after running commit", int'(ratio_o), want);
        @(negedge clk_i);
        rst_ni = 1'b0;
        #1;
        chk(!clk_div_o && !clk_en_o, "R5", "outputs after hold", int'({clk_div_o, clk_en_o}), 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        por_ni = 1'b0; rst_ni = 1'b0; commit_i = 1'b0; code_i = 4'h9;
        repeat (3) @(negedge clk_i);
        por_ni = 1'b1;
        @(negedge clk_i);
        chk(ratio_o == 5'd1, "R1", "default ratio", int'(ratio_o), 1);
        chk(!clk_div_o && !clk_en_o, "R5", "reset outputs", int'({clk_div_o, clk_en_o}), 0);
        // R1: default runs as pass-through
        run_code(0, 1'b0, 1'b0, 4);
        // R4: code change without commit while in hold is ignored
        code_i = 4'h7;
        repeat (2) @(negedge clk_i);
        chk(ratio_o == 5'd1, "R4", "ratio without commit", int'(ratio_o), 1);
        for (int c = 0; c < 16; c++)
            run_code(c, 1'b1, (c == 5) || (c == 12), 3);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule